// File: doc/BRIEF.md
# Dual Digital Phase Comparator

This block measures the phase relation between a reference square wave and a feedback square wave. It feeds the digital error terms of a phase-locked loop's filter. Both inputs pass through a synchroniser clocked by a fast system clock, so every edge is found on that clock. The two synchronised signals drive two detectors in parallel.

The first detector is an exclusive-OR stage. When both inputs run at 50% duty cycle, its average output is one half where the inputs sit a quarter period apart. That quarter-period offset is its lock point. The second detector responds only to rising edges and so ignores duty cycle. A reference edge asks the loop to speed up and a feedback edge asks it to slow down, which pulls the two inputs toward zero phase difference. It also raises a lock flag whenever no correction is pending.

Top module: `dual_phase_cmp`

## Requirements
- R1: `xor_err` equals `ref_in ^ fb_in` as sampled on the rising clock edge two edges earlier: inputs sampled on edge k show on the outputs just after edge k+2. The edge detector uses the same latency.
- R2: With both inputs square at 50% duty, the same period, and the feedback a quarter period behind, `xor_err` is high on exactly half of the cycles.
- R3: A rising reference edge sets the up state. While only the up state is set, `pfd_err` is 2'b01.
- R4: A rising feedback edge sets the down state. While only the down state is set, `pfd_err` is 2'b10.
- R5: When up and down are both set, `pfd_err` is 2'b00 and both clear on the next edge. A rising edge that arrives in that clearing cycle is kept and sets its own state.
- R6: Only rising edges matter. Inputs whose rising edges coincide never produce 2'b01 or 2'b10, whatever their duty cycles.
- R7: `lock_det` is 1 exactly when neither state is set. It stays 0 for the whole of every error pulse and for the one-cycle both-set state.
- R8: When the feedback runs slower than the reference, cycles with 2'b01 outnumber cycles with 2'b10.
- R9: Synchronous active-high `rst` clears both states and the synchroniser. After a reset edge, `xor_err` is 0, `pfd_err` is 2'b00 and `lock_det` is 1.
- R10: `pfd_err` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than either input |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal, asynchronous |
| xor_err | output | 1 | Exclusive-OR phase error, registered |
| pfd_err | output | 2 | Edge-detector error: 01 up, 10 down, 00 hold |
| lock_det | output | 1 | High while the edge detector holds no correction |

## Verification
The bench builds the block with the default of two synchroniser stages. This gives a fixed two-edge latency, so every expected value can be dated to an exact cycle. With that timing, a rising edge can land exactly inside the one-cycle both-set state, so the clearing cycle that keeps a new edge (R5) can be reached on purpose. Coincident edges with very different duty cycles, phase leads in each direction and a slower feedback frequency are also reached within a few hundred cycles.

// File: rtl/phase_cmp_pkg.sv
package phase_cmp_pkg;

  // Error code driven by the edge detector.
  typedef enum logic [1:0] {
    ERR_HOLD = 2'b00,
    ERR_UP   = 2'b01,
    ERR_DOWN = 2'b10
  } err_code_e;

  // Fewer stages than this would not resolve metastability.
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // Number of channels compared: reference and feedback.
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;

endpackage

// File: rtl/pc_edge_sync.sv
// Synchroniser chain plus one history flop for rising-edge detection.
module pc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[DEPTH-2:0], din};
  end

  // chain[STAGES-1] is the settled sample; chain[STAGES] is its previous value.
  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pc_xor_detector.sv
// Quadrature-locking detector: registered exclusive-OR of the synced levels.
module pc_xor_detector (
  input  logic clk,
  input  logic rst,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= a_lvl ^ b_lvl;
  end
endmodule

// File: rtl/pc_pfd_core.sv
// Rising-edge phase-frequency detector with an up and a down state bit.
module pc_pfd_core
  import phase_cmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ref_rise,
  input  logic      fb_rise,
  output err_code_e err,
  output logic      lock
);
  logic up_q, dn_q;
  logic up_d, dn_d;
  logic both;

  assign both = up_q & dn_q;

  always_comb begin
    if (both) begin
      // Clear together; an edge arriving now starts a fresh pulse.
      up_d = ref_rise;
      dn_d = fb_rise;
    end else begin
      up_d = up_q | ref_rise;
      dn_d = dn_q | fb_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  always_comb begin
    unique case ({dn_q, up_q})
      2'b01:   err = ERR_UP;
      2'b10:   err = ERR_DOWN;
      default: err = ERR_HOLD;
    endcase
  end

  assign lock = ~(up_q | dn_q);
endmodule

// File: rtl/dual_phase_cmp.sv
module dual_phase_cmp
  import phase_cmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       fb_in,
  output logic       xor_err,
  output logic [1:0] pfd_err,
  output logic       lock_det
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] rise;
  err_code_e         err_code;

  assign raw_in[CH_REF] = ref_in;
  assign raw_in[CH_FB]  = fb_in;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
    pc_edge_sync #(.STAGES(STAGES_EFF)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .din   (raw_in[g]),
      .level (lvl[g]),
      .rise  (rise[g])
    );
  end

  pc_xor_detector u_xor (
    .clk   (clk),
    .rst   (rst),
    .a_lvl (lvl[CH_REF]),
    .b_lvl (lvl[CH_FB]),
    .err_q (xor_err)
  );

  pc_pfd_core u_pfd (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[CH_REF]),
    .fb_rise  (rise[CH_FB]),
    .err      (err_code),
    .lock     (lock_det)
  );

  assign pfd_err = err_code;
endmodule

// File: rtl/dual_phase_cmp_chk.sv
module dual_phase_cmp_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_in,
  input logic       fb_in,
  input logic       xor_err,
  input logic [1:0] pfd_err,
  input logic       lock_det
);
  // Edges since reset, saturating; gates properties that look into the past.
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  p_xor_path_r1: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5) |-> (xor_err == ($past(ref_in, 3) ^ $past(fb_in, 3))));

  p_ref_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5 && $past(ref_in, 3) && !$past(ref_in, 4)) |-> (!lock_det && pfd_err != 2'b10));

  p_fb_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5 && $past(fb_in, 3) && !$past(fb_in, 4)) |-> (!lock_det && pfd_err != 2'b01));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!lock_det && pfd_err == 2'b00) |=> !(!lock_det && pfd_err == 2'b00));

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
    lock_det |-> (pfd_err == 2'b00));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!xor_err && pfd_err == 2'b00 && lock_det));

  p_never_both_r10: assert property (@(posedge clk) disable iff (rst)
    pfd_err != 2'b11);
endmodule

bind dual_phase_cmp dual_phase_cmp_chk u_chk (.*);

// File: tb/dual_phase_cmp_bench.sv
module dual_phase_cmp_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic       xor_err;
  logic [1:0] pfd_err;
  logic       lock_det;

  always #5 clk = ~clk;

  dual_phase_cmp #(.SYNC_STAGES(2)) u_dual_phase_cmp (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .xor_err(xor_err), .pfd_err(pfd_err), .lock_det(lock_det)
  );

  typedef struct {
    int         due;
    logic       x;
    logic [1:0] e;
    logic       l;
    bit         cnt;
    string      tag;
  } exp_t;

  exp_t q[$];
  int  edge_cnt = 0;
  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 0;
  // model state
  logic m_up = 0, m_dn = 0, p_ref = 0, p_fb = 0;
  string scen_tag = "R9";
  bit  win_on = 0;
  int  win_tot, win_hi, win_up, win_dn, win_nlock;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // monitor: pops expectations due on this edge
  always @(posedge clk) begin
    edge_cnt++;
    #2;
    while (q.size() > 0 && q[0].due <= edge_cnt) begin
      exp_t it;
      it = q.pop_front();
      if (it.due == edge_cnt) begin
        chk(xor_err == it.x, {it.tag, " R1 xor_err"}, xor_err, it.x);
        chk(pfd_err == it.e, {it.tag, " pfd_err"}, pfd_err, it.e);
        chk(lock_det == it.l, {it.tag, " R7 lock_det"}, lock_det, it.l);
        if (it.cnt) begin
          win_tot++;
          if (xor_err) win_hi++;
          if (pfd_err == 2'b01) win_up++;
          if (pfd_err == 2'b10) win_dn++;
          if (!lock_det) win_nlock++;
        end
      end
    end
  end

  // driver: drives one cycle and pushes the expected outputs two edges on
  task automatic step(input logic r, input logic f);
    logic rr, rf;
    exp_t it;
    @(negedge clk);
    ref_in = r;
    fb_in = f;
    rr = r & ~p_ref;
    rf = f & ~p_fb;
    if (m_up && m_dn) begin
      m_up = rr;
      m_dn = rf;
    end else begin
      m_up = m_up | rr;
      m_dn = m_dn | rf;
    end
    it.due = edge_cnt + 3;
    it.x   = r ^ f;
    it.e   = (m_up && !m_dn) ? 2'b01 : ((m_dn && !m_up) ? 2'b10 : 2'b00);
    it.l   = !(m_up || m_dn);
    it.cnt = win_on;
    it.tag = scen_tag;
    q.push_back(it);
    p_ref = r;
    p_fb = f;
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
    #3;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    q.delete();
    @(negedge clk);
    chk(xor_err == 1'b0, "R9 xor_err after reset", xor_err, 0);
    chk(pfd_err == 2'b00, "R9 pfd_err after reset", pfd_err, 0);
    chk(lock_det == 1'b1, "R9 lock_det after reset", lock_det, 1);
    rst = 1'b0;
    ref_in = 1'b0;
    fb_in = 1'b0;
    m_up = 0; m_dn = 0; p_ref = 0; p_fb = 0;
  endtask

  task automatic open_win();
    win_tot = 0; win_hi = 0; win_up = 0; win_dn = 0; win_nlock = 0;
    win_on = 1;
  endtask

  // square waves: phase offsets in cycles, fb delayed by fb_lag
  task automatic run_waves(input int pr, input int hr, input int pf, input int hf,
                           input int fb_lag, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      logic r, f;
      r = (i % pr) < hr;
      f = (((i - fb_lag) % pf + pf) % pf) < hf;
      step(r, f);
    end
    win_on = 0;
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", edge_cnt);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();

    // R1 R2: quadrature, 50% duty
    scen_tag = "R2";
    open_win();
    run_waves(8, 4, 8, 4, 2, 64);
    chk(win_hi * 2 == win_tot, "R2 xor high cycles (x2) vs window", win_hi * 2, win_tot);

    // R3: reference leads by 3 cycles
    do_reset();
    scen_tag = "R3";
    open_win();
    run_waves(16, 8, 16, 8, 3, 64);
    chk(win_up == 12, "R3 up cycles", win_up, 12);
    chk(win_dn == 0, "R3 down cycles", win_dn, 0);

    // R4: feedback leads by 5 cycles
    do_reset();
    scen_tag = "R4";
    open_win();
    run_waves(16, 8, 16, 8, -5, 64);
    chk(win_dn == 20, "R4 down cycles", win_dn, 20);
    chk(win_up == 0, "R4 up cycles", win_up, 0);

    // R6 R5 R7: coincident rising edges, 25% vs 75% duty
    do_reset();
    scen_tag = "R6";
    open_win();
    run_waves(16, 4, 16, 12, 0, 64);
    chk(win_up + win_dn == 0, "R6 error cycles with aligned edges", win_up + win_dn, 0);
    chk(win_nlock == 4, "R5 R7 lock low cycles (one per coincidence)", win_nlock, 4);

    // R5: rising edge inside the clearing cycle is kept
    do_reset();
    scen_tag = "R5";
    step(1, 0); step(1, 0); step(0, 1); step(1, 1);
    step(1, 1); step(1, 1); step(0, 0); step(0, 0);
    drain();

    // R8: feedback slower than reference
    do_reset();
    scen_tag = "R8";
    open_win();
    run_waves(16, 8, 24, 12, 0, 192);
    chk(win_up > win_dn, "R8 up cycles exceed down cycles", win_up, win_dn);

    // R9: reset while an up pulse is pending
    do_reset();
    scen_tag = "R9";
    step(1, 0); step(1, 0); step(1, 0);
    do_reset();
    step(0, 0); step(0, 0);
    drain();

    finish_run();
  end
endmodule